// File: doc/BRIEF.md
# Keyboard Host Command Transmitter

This block is the host end of a two-wire, open-collector keyboard link. It sends one command byte to the keyboard. The host begins by holding the clock line low. The keyboard answers by releasing the data line and then generates every clock edge of the transfer. The block presents each bit while the clock is high, and the keyboard samples it on the falling edge.

Eight data bits go out least significant first. An odd-parity bit follows them, then a stop phase in which the host releases data and waits for the keyboard to pull data low as an acknowledge. The block drives both lines only through pull-low enables and reads them through two-flop synchronizers. A divider turns the system clock into a microsecond tick, and every wait is timed in those ticks.

A completed transfer gives a one-cycle `done` pulse. A timeout gives a one-cycle `error` pulse together with a code that names the step that stalled. While the block is ready, the host can hold the keyboard silent by asserting the inhibit input.

Top module: `kbd_cmd_tx`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0. With `inhibit_req` low, neither pull-low enable is asserted.
- R2: While ready, `inhibit_req`=1 asserts `kb_clk_drive_low` and keeps `kb_dat_drive_low` at 0.
- R3: A `cmd_valid` accepted while ready raises `busy` on the next cycle. It also asserts `kb_clk_drive_low` with data released, and the block holds that state until the synchronized data line reads high. The clock line is then released.
- R4: Bits are placed on data while the keyboard clock is high, in this order: `cmd_byte[0]` first through `cmd_byte[7]`, then a parity bit chosen so that the nine bits hold an odd number of ones. A 1 is sent by releasing data and a 0 by pulling it low, and the level is held until the clock falls.
- R5: After the parity bit, the block waits for clock high and then releases data. It waits to see data high, and then for the keyboard to pull data low. At that point it pulses `done` for one cycle with `err_code`=0x00 and both lines released.
- R6: If data does not read high within REQ_TICKS ticks of the request, the transfer fails with code 0x30.
- R7: For data bit i (0..7), a missed clock-high fails with code 0x40+i and a missed clock-low fails with code 0x48+i. Each wait is limited to STEP_TICKS ticks.
- R8: For the parity bit, a missed clock-high fails with code 0x34 and a missed clock-low fails with code 0x35.
- R9: In the stop phase, a missed clock-high fails with code 0x34. A missing release-high or acknowledge-low fails with code 0x36.
- R10: On any failure, `error` pulses for one cycle with `err_code` holding the code, both enables drop to 0, and the block returns to ready and accepts a new command.
- R11: `cmd_valid` is ignored while `busy` is 1: the byte in flight is not altered.
- R12: One tick lasts TICK_DIV system cycles. A step times out after STEP_TICKS ticks, or REQ_TICKS ticks for the request step, counted from the cycle the step is entered, within one tick of jitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start strobe, taken only while ready |
| cmd_byte | input | 8 | Command byte to send |
| inhibit_req | input | 1 | Hold the keyboard silent while ready |
| kb_clk_in | input | 1 | Keyboard clock line level (asynchronous) |
| kb_dat_in | input | 1 | Keyboard data line level (asynchronous) |
| kb_clk_drive_low | output | 1 | Pull clock line low when 1 |
| kb_dat_drive_low | output | 1 | Pull data line low when 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| err_code | output | 8 | Step code of the last failure, 0x00 after success |

## Verification
The assertions assume that the keyboard moves the lines slowly compared with the system clock. Each level is assumed to last many cycles, so the two-cycle synchronizer delay never hides an edge. They also assume that `cmd_valid` is a synchronous, single-cycle strobe.

The bench's keyboard model keeps its clock at 60 ticks high and 30 ticks low, which is well inside the step limit. It changes the lines only a whole number of ticks apart, and it pulses `cmd_valid` for one cycle from negative-edge-aligned tasks. In fault mode it stops at a chosen step and holds the lines there for longer than the limit before it lets go.

// File: rtl/kbd_tx_pkg.sv
package kbd_tx_pkg;

  typedef enum logic [2:0] {
    ST_READY, ST_REQ, ST_WHI, ST_WLO, ST_STOP_HI, ST_REL, ST_ACK
  } tx_state_e;

  localparam logic [3:0] LAST_BIT = 4'd8;

  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [7:0] step_code(input tx_state_e st, input logic [3:0] idx);
    logic [7:0] c;
    unique case (st)
      ST_REQ:     c = 8'h30;
      ST_WHI:     c = (idx == LAST_BIT) ? 8'h34 : (8'h40 | {5'd0, idx[2:0]});
      ST_WLO:     c = (idx == LAST_BIT) ? 8'h35 : (8'h48 | {5'd0, idx[2:0]});
      ST_STOP_HI: c = 8'h34;
      ST_REL:     c = 8'h36;
      ST_ACK:     c = 8'h36;
      default:    c = 8'h00;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/kbd_tx_tick.sv
module kbd_tx_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(DIV - 1));

      assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/kbd_tx_sync.sv
module kbd_tx_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          stab_q <= 1'b1;
        end else begin
          meta_q <= din[i];
          stab_q <= meta_q;
        end
      end
      assign dout[i] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/kbd_tx_timer.sv
module kbd_tx_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (tick && !expired)  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && $past(!restart)) |-> (cnt_q <= limit));
endmodule

// File: rtl/kbd_cmd_tx.sv
module kbd_cmd_tx
  import kbd_tx_pkg::*;
#(
  parameter int TICK_DIV   = 50,
  parameter int REQ_TICKS  = 300,
  parameter int STEP_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       inhibit_req,
  input  logic       kb_clk_in,
  input  logic       kb_dat_in,
  output logic       kb_clk_drive_low,
  output logic       kb_dat_drive_low,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [7:0] err_code
);
  localparam int TMAX = (REQ_TICKS > STEP_TICKS) ? REQ_TICKS : STEP_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  tx_state_e  state_q, state_d;
  logic [3:0] idx_q, idx_d;
  logic [8:0] sh_q, sh_d;
  logic       dlow_q, dlow_d;
  logic       done_q, done_d, err_q, err_d;
  logic [7:0] code_q, code_d;

  logic          tick, expired, step_go, to_fail;
  logic [1:0]    lines_s;
  logic          clk_s, dat_s;
  logic [TW-1:0] limit;

  kbd_tx_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  kbd_tx_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({kb_clk_in, kb_dat_in}), .dout(lines_s));
  assign clk_s = lines_s[1];
  assign dat_s = lines_s[0];

  assign limit   = (state_q == ST_REQ) ? TW'(REQ_TICKS) : TW'(STEP_TICKS);
  assign step_go = (state_d != state_q) || (state_q == ST_READY);

  kbd_tx_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(step_go), .tick(tick),
    .limit(limit), .expired(expired));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    dlow_d  = dlow_q;
    code_d  = code_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    to_fail = 1'b0;
    unique case (state_q)
      ST_READY: if (cmd_valid) begin
        sh_d    = {odd_parity(cmd_byte), cmd_byte};
        idx_d   = '0;
        code_d  = '0;
        dlow_d  = 1'b0;
        state_d = ST_REQ;
      end
      ST_REQ: begin
        if (dat_s)        state_d = ST_WHI;
        else if (expired) to_fail = 1'b1;
      end
      ST_WHI: begin
        if (clk_s) begin
          dlow_d  = ~sh_q[0];
          state_d = ST_WLO;
        end else if (expired) to_fail = 1'b1;
      end
      ST_WLO: begin
        if (!clk_s) begin
          sh_d = sh_q >> 1;
          if (idx_q == LAST_BIT) state_d = ST_STOP_HI;
          else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_WHI;
          end
        end else if (expired) to_fail = 1'b1;
      end
      ST_STOP_HI: begin
        if (clk_s) begin
          dlow_d  = 1'b0;
          state_d = ST_REL;
        end else if (expired) to_fail = 1'b1;
      end
      ST_REL: begin
        if (dat_s)        state_d = ST_ACK;
        else if (expired) to_fail = 1'b1;
      end
      ST_ACK: begin
        if (!dat_s) begin
          done_d  = 1'b1;
          code_d  = '0;
          state_d = ST_READY;
        end else if (expired) to_fail = 1'b1;
      end
      default: state_d = ST_READY;
    endcase
    if (to_fail) begin
      err_d   = 1'b1;
      code_d  = step_code(state_q, idx_q);
      dlow_d  = 1'b0;
      state_d = ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      idx_q   <= '0;
      sh_q    <= '0;
      dlow_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      dlow_q  <= dlow_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end

  assign kb_clk_drive_low = (state_q == ST_REQ) || ((state_q == ST_READY) && inhibit_req);
  assign kb_dat_drive_low = dlow_q;
  assign busy             = (state_q != ST_READY);
  assign done             = done_q;
  assign error            = err_q;
  assign err_code         = code_q;

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !inhibit_req) |-> (!kb_clk_drive_low && !kb_dat_drive_low));
  assert_inhibit_data_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inhibit_req) |-> !kb_dat_drive_low);
  assert_request_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (kb_clk_drive_low && !kb_dat_drive_low));
  assert_bit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WLO && $past(state_q) == ST_WLO) |-> $stable(kb_dat_drive_low));
  assert_done_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 8'h00));
  assert_error_code_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (err_code != 8'h00));
  assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_end_reported_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));
endmodule

// File: tb/sim_kbd_cmd_tx.sv
`timescale 1ns/1ps
module sim_kbd_cmd_tx;
  localparam int TDIV = 5;
  localparam int REQ  = 300;
  localparam int STEP = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic inhibit_req = 1'b0;
  logic kb_clk_low = 1'b0;
  logic kb_dat_low = 1'b1;
  logic host_clk_low, host_dat_low, busy, done, error;
  logic [7:0] err_code;
  logic clk_line, dat_line;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign clk_line = ~(host_clk_low | kb_clk_low);
  assign dat_line = ~(host_dat_low | kb_dat_low);

  kbd_cmd_tx #(.TICK_DIV(TDIV), .REQ_TICKS(REQ), .STEP_TICKS(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .inhibit_req(inhibit_req), .kb_clk_in(clk_line), .kb_dat_in(dat_line),
    .kb_clk_drive_low(host_clk_low), .kb_dat_drive_low(host_dat_low),
    .busy(busy), .done(done), .error(error), .err_code(err_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n * TDIV) @(posedge clk);
  endtask

  // Keyboard model. mode 0 normal, 1 never raises data, 2 clock stuck low before
  // bit k (k=9 is the stop phase), 3 clock stuck high in bit k, 4 never acknowledges.
  task automatic kb_model(input int mode, input int k, output logic [8:0] rx, output logic stopbit);
    rx = '0;
    stopbit = 1'b0;
    wait (clk_line == 1'b0);
    wt(10);
    if (mode == 1) begin wt(REQ + 20); return; end
    kb_dat_low = 1'b0;
    kb_clk_low = 1'b1;
    wt(30);
    for (int i = 0; i < 10; i++) begin
      if (mode == 2 && k == i) begin
        wt(STEP + 20); kb_clk_low = 1'b0; kb_dat_low = 1'b1; return;
      end
      kb_clk_low = 1'b0;
      if (i == 9) break;
      if (mode == 3 && k == i) begin
        wt(STEP + 20); kb_dat_low = 1'b1; return;
      end
      wt(60);
      rx[i] = dat_line;
      kb_clk_low = 1'b1;
      wt(30);
    end
    wt(20);
    stopbit = dat_line;
    if (mode == 4) begin wt(STEP + 20); kb_dat_low = 1'b1; return; end
    kb_dat_low = 1'b1;
    wt(5);
  endtask

  task automatic wait_result(output bit got_done, output bit got_err, output logic [7:0] code,
                             output int cycles);
    got_done = 0; got_err = 0; code = '0; cycles = 0;
    while (!(done || error) && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    got_done = done;
    got_err  = error;
    code     = err_code;
    @(negedge clk);
    chk(!done && !error, "R10 single-cycle result pulse", {done, error}, 0);
    chk(!host_clk_low && !host_dat_low, "R10 lines released after result",
        {host_clk_low, host_dat_low}, 0);
  endtask

  task automatic issue(input logic [7:0] b);
    @(negedge clk);
    cmd_byte = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_code(input int mode, input int k);
    case (mode)
      1: return 8'h30;
      2: return (k >= 8) ? 8'h34 : 8'(8'h40 + k);
      3: return (k == 8) ? 8'h35 : 8'(8'h48 + k);
      4: return 8'h36;
      default: return 8'h00;
    endcase
  endfunction

  // Normal transfer: R3, R4, R5 (and R11 when intrude is set).
  task automatic test_send(input logic [7:0] b, input bit intrude);
    logic [8:0] rx; logic sb; bit gd, ge; logic [7:0] c; int cyc;
    issue(b);
    chk(busy && host_clk_low && !host_dat_low, "R3 request drives clock low only",
        {busy, host_clk_low, host_dat_low}, 3'b110);
    fork
      kb_model(0, 0, rx, sb);
      wait_result(gd, ge, c, cyc);
      if (intrude) begin
        wt(300);
        cmd_byte = ~b;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk(rx[7:0] == b, intrude ? "R11 byte unchanged by strobe while busy" : "R4 data LSB first",
        rx[7:0], b);
    chk(rx[8] == ~(^b), "R4 odd parity bit", rx[8], ~(^b));
    chk(sb == 1'b1, "R5 stop releases data", sb, 1);
    chk(gd && !ge && c == 8'h00, "R5 done with zero code", {gd, ge, c}, {2'b10, 8'h00});
  endtask

  // Timeout scenarios: R6, R7, R8, R9, R10.
  task automatic test_fault(input int mode, input int k, input string req);
    logic [8:0] rx; logic sb; bit gd, ge; logic [7:0] c; int cyc;
    issue(8'h5A);
    fork
      kb_model(mode, k, rx, sb);
      wait_result(gd, ge, c, cyc);
    join
    chk(ge && !gd && c == exp_code(mode, k), req, {gd, ge, c}, {2'b01, exp_code(mode, k)});
    if (mode == 1)
      chk(cyc >= (REQ - 1) * TDIV && cyc <= REQ * TDIV + 4, "R12 request timeout span",
          cyc, REQ * TDIV);
    wt(5);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!busy && !done && !error, "R1 reset status", {busy, done, error}, 0);
    chk(!host_clk_low && !host_dat_low, "R1 lines released", {host_clk_low, host_dat_low}, 0);
  endtask

  task automatic test_inhibit();
    @(negedge clk);
    inhibit_req = 1'b1;
    @(negedge clk);
    chk(host_clk_low && !host_dat_low && !busy, "R2 inhibit holds clock low",
        {host_clk_low, host_dat_low}, 2'b10);
    inhibit_req = 1'b0;
    @(negedge clk);
    chk(!host_clk_low, "R2 inhibit released", host_clk_low, 0);
    wt(5);
  endtask

  task automatic test_request_stall();
    logic [8:0] rx; logic sb; bit gd, ge; logic [7:0] c; int cyc;
    issue(8'h11);
    fork
      kb_model(1, 0, rx, sb);
      begin
        wt(150);
        @(negedge clk);
        chk(busy && host_clk_low && !host_dat_low, "R3 request held until data high",
            {busy, host_clk_low, host_dat_low}, 3'b110);
        wait_result(gd, ge, c, cyc);
      end
    join
    chk(ge && c == 8'h30, "R6 request timeout code", c, 8'h30);
    wt(5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    test_reset();
    test_inhibit();
    test_send(8'hA5, 0);
    test_send(8'h00, 0);
    test_send(8'hFF, 0);
    test_send(8'h01, 1);
    test_request_stall();
    test_fault(1, 0, "R6 no start code");
    test_fault(2, 0, "R7 bit0 clock-high timeout");
    test_fault(2, 3, "R7 bit3 clock-high timeout");
    test_fault(3, 0, "R7 bit0 clock-low timeout");
    test_fault(3, 5, "R7 bit5 clock-low timeout");
    test_fault(2, 8, "R8 parity clock-high timeout");
    test_fault(3, 8, "R8 parity clock-low timeout");
    test_fault(2, 9, "R9 stop clock-high timeout");
    test_fault(4, 0, "R9 acknowledge timeout");
    test_send(8'h3C, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule